// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits between a synchronous host and an external asynchronous ROM that offers a fast read inside an open page. The host presents one request at a time, as an address and a width flag, through a valid/ready handshake. The controller then drives the ROM's address lines, chip select, output enable and width-select pin. It waits a fixed number of clock cycles and captures the data bus. The result comes back as a single-cycle response strobe carrying 32 bits of data. In narrow mode the upper half of the response is zero.

The controller remembers which page the ROM last opened and in which width mode. A request to that same page, in the same mode, waits only the short in-page latency. Any other request waits the full random-access latency. The host address is a 16-bit-unit (half-word) address. Bits above the eight-entry page offset form the page tag in both modes. In narrow mode the lowest address bit leaves on the top data pin, which the controller then drives as an output.

A width change while the ROM is selected needs a bus turnaround. The controller deselects the ROM, waits a programmable number of cycles for the ROM outputs to float, and only then flips the width pin and starts driving the top data pin. The request is then served as a page miss.

Top module: `pgrom_rd_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, rom_ce_n and rom_oe_n are 1, rom_wide is 1 and rom_lsb_oe is 0.
- R2: A request whose page tag (req_addr bits above bit 3) or width mode differs from the last access, or that is the first access after reset, produces rsp_valid exactly RAND_CYC clock edges after the accepting edge.
- R3: A request in the same page and the same mode as the previous access produces rsp_valid exactly PAGE_CYC edges after the accepting edge.
- R4: In wide mode (req_half=0), rom_addr carries req_addr[22:1] and rsp_data equals the full 32-bit rom_dq_in sampled at the capture edge.
- R5: In narrow mode (req_half=1), rom_wide is 0, rom_addr carries req_addr[22:1], rom_lsb_oe is 1 and rom_lsb_out carries req_addr[0].
- R6: In narrow mode, rsp_data[15:0] equals rom_dq_in[15:0] and rsp_data[31:16] is zero.
- R7: A width change requested while rom_ce_n is 0 first holds rom_ce_n and rom_oe_n at 1 for TURN_CYC cycles, then serves the request as a miss: the response comes TURN_CYC+RAND_CYC edges after acceptance. The controller never drives the top data pin while the ROM has it enabled as an output. rom_oe_n is 0 only while rom_ce_n is 0.
- R8: Only one request is outstanding: req_ready is 0 from the accepting edge until the response, and rsp_valid is high for one cycle only.
- R9: rom_addr stays constant from the accepting edge through the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_addr | input | 23 | Half-word address of the request |
| req_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Read data, zero-extended in 16-bit mode |
| rom_addr | output | 22 | ROM address lines |
| rom_ce_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_wide | output | 1 | ROM width select, 1 = 32-bit |
| rom_dq_in | input | 32 | ROM data bus as seen by the controller |
| rom_lsb_out | output | 1 | Lowest address bit driven on the top data pin |
| rom_lsb_oe | output | 1 | Drive enable for the top data pin |

## Verification
Two events can share a clock edge: the response to one read and the acceptance of the next. The hit decision for the new read must then use the tag written by the read just accepted. The bench provokes this by issuing each request on the very cycle the previous response is visible. It judges the result by the latency of the follow-on read and the data it returns. A behavioural ROM model on the bench side returns poison data unless the address has been stable for the random or page latency. Both a wrong hit decision and a short wait therefore show up as wrong data or wrong latency.

// File: rtl/pgrom_pkg.sv
// Shared types of the page-mode ROM read controller.
// Assumes nothing beyond a SystemVerilog compiler.
package pgrom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TURN   = 2'd1,
        ST_ACCESS = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/pgrom_page_tag.sv
// Open-page tracker: holds the page tag and width mode of the last ROM access
// and reports whether a new request falls into that page in the same mode.
// Assumes clear and update are never asserted together by the caller.
module pgrom_page_tag #(
    parameter int PAGE_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              update,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              wr_half,
    input  logic [PAGE_W-1:0] cmp_page,
    input  logic              cmp_half,
    output logic              hit
);
    logic              valid_q;
    logic [PAGE_W-1:0] page_q;
    logic              half_q;

    // Tag storage: invalidated on reset or clear, reloaded on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
            half_q  <= 1'b0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (update) begin
            valid_q <= 1'b1;
            page_q  <= wr_page;
            half_q  <= wr_half;
        end
    end

    // Hit compare against the stored tag.
    always_comb begin
        hit = valid_q && (page_q == cmp_page) && (half_q == cmp_half);
    end
endmodule

// File: rtl/pgrom_lat_count.sv
// Down counter for wait windows: loaded with N, it flags expire during the
// N-th cycle after the load edge. Assumes N >= 1.
module pgrom_lat_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last cycle of the window.
    always_comb begin
        expire = (cnt_q == CNT_W'(1));
    end
endmodule

// File: rtl/pgrom_rd_capture.sv
// Response stage: samples the ROM data bus on capture and presents it as a
// one-cycle strobe, zero-extending the low half in narrow mode.
// Assumes HALF_W <= DATA_W.
module pgrom_rd_capture #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              half_mode,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [DATA_W-1:0] shaped;

    // Width shaping of the sampled bus.
    always_comb begin
        if (half_mode) begin
            shaped = {{(DATA_W-HALF_W){1'b0}}, bus_in[HALF_W-1:0]};
        end else begin
            shaped = bus_in;
        end
    end

    // Response register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_data <= shaped;
            end
        end
    end
endmodule

// File: rtl/pgrom_rd_ctrl.sv
// Page-mode ROM read controller (top). Accepts one half-word-addressed read at
// a time, drives the ROM pins, waits the page or random latency and returns
// the data. Assumes RAND_CYC, PAGE_CYC, TURN_CYC >= 1, already rounded up
// from the ROM's ns figures for the clock period in use.
module pgrom_rd_ctrl #(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 32,
    parameter int PAGE_LSB = 3,
    parameter int RAND_CYC = 12,
    parameter int PAGE_CYC = 3,
    parameter int TURN_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W:0]     req_addr,
    input  logic                req_half,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic                rom_ce_n,
    output logic                rom_oe_n,
    output logic                rom_wide,
    input  logic [DATA_W-1:0]   rom_dq_in,
    output logic                rom_lsb_out,
    output logic                rom_lsb_oe
);
    import pgrom_pkg::*;

    localparam int HA_W   = ADDR_W + 1;
    localparam int PAGE_W = ADDR_W - PAGE_LSB;
    localparam int MAX_AB = (RAND_CYC > PAGE_CYC) ? RAND_CYC : PAGE_CYC;
    localparam int MAXC   = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    ctl_state_t        state_q;
    logic              pend_half_q;
    logic [PAGE_W-1:0] pend_page_q;
    logic [PAGE_W-1:0] req_page;
    logic              accept;
    logic              need_turn;
    logic              hit;
    logic              expire;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              turn_done;
    logic              capture;
    logic              tag_clear;
    logic              tag_update;
    logic [PAGE_W-1:0] tag_wr_page;
    logic              tag_wr_half;

    // Request decode: acceptance, page field and turnaround need.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        req_page  = req_addr[HA_W-1:PAGE_LSB+1];
        need_turn = accept && (req_half == rom_wide) && !rom_ce_n;
        turn_done = (state_q == ST_TURN) && expire;
        capture   = (state_q == ST_ACCESS) && expire;
    end

    // Tag maintenance: cleared on deselect, written when the access starts.
    always_comb begin
        tag_clear   = need_turn;
        tag_update  = (accept && !need_turn) || turn_done;
        tag_wr_page = turn_done ? pend_page_q : req_page;
        tag_wr_half = turn_done ? pend_half_q : req_half;
    end

    // Counter load selection for turnaround, page hit or random access.
    always_comb begin
        cnt_load = accept || turn_done;
        if (need_turn) begin
            cnt_val = CNT_W'(TURN_CYC);
        end else if (accept && hit) begin
            cnt_val = CNT_W'(PAGE_CYC);
        end else begin
            cnt_val = CNT_W'(RAND_CYC);
        end
    end

    pgrom_page_tag #(.PAGE_W(PAGE_W)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tag_clear),
        .update   (tag_update),
        .wr_page  (tag_wr_page),
        .wr_half  (tag_wr_half),
        .cmp_page (req_page),
        .cmp_half (req_half),
        .hit      (hit)
    );

    pgrom_lat_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expire   (expire)
    );

    pgrom_rd_capture #(.DATA_W(DATA_W), .HALF_W(DATA_W/2)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .half_mode (!rom_wide),
        .bus_in    (rom_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // Sequencer and ROM pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rom_addr    <= '0;
            rom_ce_n    <= 1'b1;
            rom_oe_n    <= 1'b1;
            rom_wide    <= 1'b1;
            rom_lsb_out <= 1'b0;
            rom_lsb_oe  <= 1'b0;
            pend_half_q <= 1'b0;
            pend_page_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rom_addr    <= req_addr[HA_W-1:1];
                        rom_lsb_out <= req_addr[0];
                        pend_half_q <= req_half;
                        pend_page_q <= req_page;
                        if (need_turn) begin
                            rom_ce_n   <= 1'b1;
                            rom_oe_n   <= 1'b1;
                            rom_lsb_oe <= 1'b0;
                            state_q    <= ST_TURN;
                        end else begin
                            rom_ce_n   <= 1'b0;
                            rom_oe_n   <= 1'b0;
                            rom_wide   <= !req_half;
                            rom_lsb_oe <= req_half;
                            state_q    <= ST_ACCESS;
                        end
                    end
                end
                ST_TURN: begin
                    if (expire) begin
                        rom_ce_n   <= 1'b0;
                        rom_oe_n   <= 1'b0;
                        rom_wide   <= !pend_half_q;
                        rom_lsb_oe <= pend_half_q;
                        state_q    <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (expire) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// Protocol checker for pgrom_rd_ctrl, attached by the bind below.
module pgrom_rd_ctrl_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              rom_wide,
    input logic              rom_lsb_oe
);
    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(rom_addr));
    // R7
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);
    // R7
    no_pin_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_lsb_oe |-> !rom_wide);
    // R8
    rsp_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
endmodule

bind pgrom_rd_ctrl pgrom_rd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rom_addr   (rom_addr),
    .rom_ce_n   (rom_ce_n),
    .rom_oe_n   (rom_oe_n),
    .rom_wide   (rom_wide),
    .rom_lsb_oe (rom_lsb_oe)
);

// File: tb/pgrom_rd_ctrl_tb.sv
// Directed bench for pgrom_rd_ctrl with a behavioural page-mode ROM model.
module pgrom_rd_ctrl_tb_top;
    localparam int RAND_CYC = 12;
    localparam int PAGE_CYC = 3;
    localparam int TURN_CYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic        req_half = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [21:0] rom_addr;
    logic        rom_ce_n, rom_oe_n, rom_wide;
    logic [31:0] rom_dq_in;
    logic        rom_lsb_out, rom_lsb_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pgrom_rd_ctrl #(.RAND_CYC(RAND_CYC), .PAGE_CYC(PAGE_CYC), .TURN_CYC(TURN_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_half(req_half), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_wide(rom_wide), .rom_dq_in(rom_dq_in),
        .rom_lsb_out(rom_lsb_out), .rom_lsb_oe(rom_lsb_oe)
    );

    // ROM contents as a function of the 32-bit word address.
    function automatic logic [31:0] rom_word(input logic [21:0] a);
        return {a, 10'h0} ^ {10'h0, a} ^ 32'hC3A5_1E0F;
    endfunction

    // ROM timing model: stability counters updated at the falling edge.
    int  pg_cnt = 0;
    int  lo_cnt = 0;
    int  off_cnt = 100;
    logic [20:0] prev_pg = '1;
    logic [3:0]  prev_lo = '1;
    logic        prev_lsb_oe = 1'b0;
    logic        rom_ok = 1'b0;

    always @(negedge clk) begin
        logic [20:0] pg;
        logic [3:0]  lo;
        pg = {rom_ce_n, rom_wide, rom_addr[21:3]};
        lo = {rom_addr[2:0], rom_wide ? 1'b0 : rom_lsb_out};
        pg_cnt = (pg != prev_pg || rom_ce_n) ? 0 : pg_cnt + 1;
        lo_cnt = (lo != prev_lo) ? 0 : lo_cnt + 1;
        prev_pg = pg;
        prev_lo = lo;
        rom_ok = !rom_ce_n && !rom_oe_n && (pg_cnt + 1 >= RAND_CYC) && (lo_cnt + 1 >= PAGE_CYC);
        if (rom_wide && !rom_ce_n && !rom_oe_n) off_cnt = 0;
        else if (off_cnt < 100) off_cnt = off_cnt + 1;
        if (rst_n && rom_lsb_oe && !prev_lsb_oe) begin
            tests++;
            if (off_cnt < TURN_CYC) begin
                fails++;
                $display("FAIL R7 pin float before drive: %0d expected >= %0d", off_cnt, TURN_CYC);
            end
        end
        if (rst_n && rom_lsb_oe && rom_wide && !rom_ce_n && !rom_oe_n) begin
            fails++;
            $display("FAIL R7 bus fight on top pin: 1 expected 0");
        end
        prev_lsb_oe = rom_lsb_oe;
    end

    always_comb begin
        if (!rom_ok) rom_dq_in = 32'hDEAD_BEEF;
        else if (rom_wide) rom_dq_in = rom_word(rom_addr);
        else rom_dq_in = {rom_lsb_out, 15'h5A3C,
                          rom_lsb_out ? rom_word(rom_addr)[31:16] : rom_word(rom_addr)[15:0]};
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One read: issue at the falling edge, measure latency, check data and pins.
    task automatic do_read(input logic [22:0] ha, input bit half, input int exp_lat, input string tag);
        int lat;
        bit ready_ok;
        bit addr_ok;
        logic [31:0] w;
        logic [31:0] exp_d;
        req_addr  = ha;
        req_half  = half;
        req_valid = 1'b1;
        for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        ready_ok = 1'b1;
        addr_ok = 1'b1;
        while (!rsp_valid && lat < 60) begin
            if (req_ready) ready_ok = 1'b0;
            if (rom_addr != ha[22:1]) addr_ok = 1'b0;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        w = rom_word(ha[22:1]);
        exp_d = half ? {16'h0, ha[0] ? w[31:16] : w[15:0]} : w;
        check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        check(ready_ok, "R8 ready low while busy", {31'h0, ready_ok}, 1);
        check(addr_ok, "R9 address held", rom_addr, {9'h0, ha[22:1]});
        if (half) begin
            check(rsp_data == exp_d, "R6 narrow data zero-extended", rsp_data, exp_d);
            check(!rom_wide && rom_lsb_oe && rom_lsb_out == ha[0], "R5 narrow pins",
                  {29'h0, rom_wide, rom_lsb_oe, rom_lsb_out}, {30'h1, ha[0]});
        end else begin
            check(rsp_data == exp_d, "R4 wide data", rsp_data, exp_d);
        end
    endtask

    task automatic t_reset();
        check(req_ready && !rsp_valid, "R1 ready/valid after reset", {30'h0, req_ready, rsp_valid}, 32'h2);
        check(rom_ce_n && rom_oe_n, "R1 ROM deselected", {30'h0, rom_ce_n, rom_oe_n}, 32'h3);
        check(rom_wide && !rom_lsb_oe, "R1 wide, pin released", {30'h0, rom_wide, rom_lsb_oe}, 32'h2);
    endtask

    task automatic t_miss_and_hit();
        do_read(23'h000100, 1'b0, RAND_CYC, "R2 first access miss");
        do_read(23'h00010A, 1'b0, PAGE_CYC, "R3 same-page hit");
        do_read(23'h00010E, 1'b0, PAGE_CYC, "R3 second hit");
    endtask

    task automatic t_page_cross();
        do_read(23'h000110, 1'b0, RAND_CYC, "R2 next page miss");
        do_read(23'h7FFFF2, 1'b0, RAND_CYC, "R2 far page miss");
        do_read(23'h7FFFFF, 1'b0, PAGE_CYC, "R3 top entry hit");
    endtask

    task automatic t_mode_switch();
        do_read(23'h7FFFF1, 1'b1, TURN_CYC + RAND_CYC, "R7 turnaround to narrow");
        do_read(23'h7FFFFE, 1'b1, PAGE_CYC, "R3 narrow hit");
        do_read(23'h7FFFFF, 1'b1, PAGE_CYC, "R3 narrow hit odd half");
        do_read(23'h7FFFF8, 1'b0, TURN_CYC + RAND_CYC, "R7 turnaround to wide");
    endtask

    task automatic t_pulse();
        @(negedge clk);
        check(!rsp_valid, "R8 single-cycle strobe", {31'h0, rsp_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_miss_and_hit();
        t_page_cross();
        t_mode_switch();
        t_pulse();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: run hung");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule